// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block makes the control-flow decision for a small 8-bit processor core. The decoder supplies a request that carries several items:

- the class of the control-flow instruction;
- the current program counter;
- the status byte and a flag index;
- a signed offset;
- the tested register bit and the tested I/O bit, together with that I/O bit's address;
- an equality result from the compare datapath;
- whether the instruction after the current one occupies two words.

From these the block decides whether the flow changes. It returns the next program counter and the number of cycles the instruction occupies.

Four kinds of decision are covered. Conditional relative branches may test any status bit for set or clear. Named aliases decide signed and unsigned comparisons. Unconditional relative jumps and calls compute a target from a wider offset. Compare-or-bit-test skips jump over one or two words. Each accepted request produces its result one clock later, and that result stays on the outputs until the next request arrives. Program-counter arithmetic wraps at the program-memory size. Fetching instructions and managing the return stack are done by other blocks.

Top module: `bsk_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the outputs: `out_valid`=0, `out_taken`=0, `out_next_pc`=0, `out_cycles`=0. This happens even if a request is present at the same time.
- R2: A request sampled with `req_valid`=1 produces its result on the outputs after the next rising edge, with `out_valid`=1 for exactly that cycle. An edge at which `req_valid`=0 leaves `out_valid`=0.
- R3: Status-bit branches use two codes. Code 1 is taken when `sreg_in[flag_sel]` is 1, and code 2 is taken when it is 0. A taken branch goes to pc + sext(`offset_in[6:0]`) + 1. Bits 11..7 of the offset are ignored.
- R4: Signed aliases use two codes. Code 3 (greater-or-equal) is taken when sreg bit 2 XOR sreg bit 3 is 0. Code 4 (less-than) is taken when that XOR is 1. Both use the branch target of R3.
- R5: Unsigned aliases use two codes. Code 5 (same-or-higher) is taken when sreg bit 0 is 0. Code 6 (lower) is taken when sreg bit 0 is 1. Both use the branch target of R3.
- R6: Codes 1 to 6 report 1 cycle when not taken and 2 cycles when taken.
- R7: Code 7 (relative jump) and code 8 (relative call) are always taken and go to pc + sext(`offset_in[11:0]`) + 1. The jump reports 2 cycles and the call reports 3 cycles.
- R8: There are three skip codes: code 9 skips when `eq_in`=1, code 10 skips when `reg_bit`=0, and code 11 skips when `reg_bit`=1. A skip over a one-word instruction (`next_two_word`=0) gives pc+2 and 2 cycles. A skip over a two-word instruction gives pc+3 and 3 cycles.
- R9: Code 12 skips when `io_bit`=0 and code 13 skips when `io_bit`=1, following R8. Either one can skip only when `io_addr` is 0x00..0x1F; at any higher address it is not taken.
- R10: A request that is not taken reports pc+1 and 1 cycle. This includes code 0 and the unused codes 14 and 15.
- R11: All targets are reduced modulo 2^PC_W, with PC_W = 10 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Control-flow class code (see R3 to R10) |
| pc_in | input | PC_W | Program counter of the instruction |
| sreg_in | input | 8 | Status byte (bit 0 carry, bit 2 negative, bit 3 overflow) |
| flag_sel | input | 3 | Status bit index for codes 1 and 2 |
| offset_in | input | 12 | Signed offset; bits 6..0 for branches, all bits for jump and call |
| reg_bit | input | 1 | Selected register bit for codes 10 and 11 |
| io_bit | input | 1 | Selected I/O bit for codes 12 and 13 |
| io_addr | input | 6 | Address of the I/O register under test |
| eq_in | input | 1 | Operands compared equal (code 9) |
| next_two_word | input | 1 | Following instruction is two words long |
| out_valid | output | 1 | Result present this cycle |
| out_taken | output | 1 | Branch, jump or skip taken |
| out_next_pc | output | PC_W | Next program counter |
| out_cycles | output | 2 | Cycle count of the instruction |

## Verification
All state in this block sits in one result register, so any decision fault reaches the ports on the cycle after the request that caused it. A wrong condition appears as a wrong `out_taken` together with a wrong `out_cycles`. A broken offset extension or skip step shows up only in `out_next_pc`, and only for offsets near the sign boundary or for requests that wrap past the top of program memory. The vectors are therefore chosen so that both polarities and both instruction lengths occur at those boundaries.

// File: rtl/bsk_pkg.sv
package bsk_pkg;

    // Control-flow class codes carried on req_op
    localparam logic [3:0] OP_NONE  = 4'd0;
    localparam logic [3:0] OP_BRSET = 4'd1;
    localparam logic [3:0] OP_BRCLR = 4'd2;
    localparam logic [3:0] OP_BRGE  = 4'd3;
    localparam logic [3:0] OP_BRLT  = 4'd4;
    localparam logic [3:0] OP_BRSH  = 4'd5;
    localparam logic [3:0] OP_BRLO  = 4'd6;
    localparam logic [3:0] OP_RJMP  = 4'd7;
    localparam logic [3:0] OP_RCALL = 4'd8;
    localparam logic [3:0] OP_SKEQ  = 4'd9;
    localparam logic [3:0] OP_SKRBC = 4'd10;
    localparam logic [3:0] OP_SKRBS = 4'd11;
    localparam logic [3:0] OP_SKIOC = 4'd12;
    localparam logic [3:0] OP_SKIOS = 4'd13;

    // Status byte bit positions used by the aliases
    localparam int SF_C = 0;
    localparam int SF_N = 2;
    localparam int SF_V = 3;

    typedef enum logic [2:0] {
        FL_SEQ,
        FL_BRANCH,
        FL_JUMP,
        FL_CALL,
        FL_SKIP
    } flow_e;

    typedef struct packed {
        logic  taken;
        flow_e flow;
    } decision_t;

    function automatic logic signed_less(input logic [7:0] s);
        return s[SF_N] ^ s[SF_V];
    endfunction

endpackage

// File: rtl/bsk_cond_eval.sv
module bsk_cond_eval
    import bsk_pkg::*;
#(
    parameter int IO_ADDR_W = 6,
    parameter int IO_LIMIT  = 32
) (
    input  logic [3:0]           op,
    input  logic [7:0]           sreg,
    input  logic [2:0]           flag_sel,
    input  logic                 reg_bit,
    input  logic                 io_bit,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 eq,
    output decision_t            dec
);
    logic io_ok;
    logic flag_bit;

    assign io_ok    = int'(io_addr) < IO_LIMIT;
    assign flag_bit = sreg[flag_sel];

    always_comb begin
        dec = '{taken: 1'b0, flow: FL_SEQ};
        unique case (op)
            OP_BRSET: dec = '{taken: flag_bit,              flow: FL_BRANCH};
            OP_BRCLR: dec = '{taken: ~flag_bit,             flow: FL_BRANCH};
            OP_BRGE:  dec = '{taken: ~signed_less(sreg),    flow: FL_BRANCH};
            OP_BRLT:  dec = '{taken: signed_less(sreg),     flow: FL_BRANCH};
            OP_BRSH:  dec = '{taken: ~sreg[SF_C],           flow: FL_BRANCH};
            OP_BRLO:  dec = '{taken: sreg[SF_C],            flow: FL_BRANCH};
            OP_RJMP:  dec = '{taken: 1'b1,                  flow: FL_JUMP};
            OP_RCALL: dec = '{taken: 1'b1,                  flow: FL_CALL};
            OP_SKEQ:  dec = '{taken: eq,                    flow: FL_SKIP};
            OP_SKRBC: dec = '{taken: ~reg_bit,              flow: FL_SKIP};
            OP_SKRBS: dec = '{taken: reg_bit,               flow: FL_SKIP};
            OP_SKIOC: dec = '{taken: io_ok & ~io_bit,       flow: FL_SKIP};
            OP_SKIOS: dec = '{taken: io_ok & io_bit,        flow: FL_SKIP};
            default:  dec = '{taken: 1'b0,                  flow: FL_SEQ};
        endcase
    end
endmodule

// File: rtl/bsk_target_gen.sv
module bsk_target_gen
    import bsk_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int BR_OFF_W  = 7,
    parameter int JMP_OFF_W = 12
) (
    input  logic [PC_W-1:0]      pc,
    input  logic [JMP_OFF_W-1:0] offset,
    input  decision_t            dec,
    input  logic                 two_word,
    output logic [PC_W-1:0]      next_pc
);
    localparam int EXT_W = (JMP_OFF_W > PC_W) ? JMP_OFF_W : PC_W;

    logic [EXT_W-1:0] pc_ext;
    logic [EXT_W-1:0] br_rel;
    logic [EXT_W-1:0] jmp_rel;
    logic [EXT_W-1:0] step;
    logic [EXT_W-1:0] sum;

    assign pc_ext  = EXT_W'(pc);
    assign br_rel  = EXT_W'($signed(offset[BR_OFF_W-1:0]));
    assign jmp_rel = EXT_W'($signed(offset));

    always_comb begin
        step = EXT_W'(1);
        if (dec.taken) begin
            unique case (dec.flow)
                FL_BRANCH: step = br_rel + EXT_W'(1);
                FL_JUMP,
                FL_CALL:   step = jmp_rel + EXT_W'(1);
                FL_SKIP:   step = two_word ? EXT_W'(3) : EXT_W'(2);
                default:   step = EXT_W'(1);
            endcase
        end
        sum = pc_ext + step;
    end

    assign next_pc = sum[PC_W-1:0];
endmodule

// File: rtl/bsk_cycle_cnt.sv
module bsk_cycle_cnt
    import bsk_pkg::*;
(
    input  decision_t  dec,
    input  logic       two_word,
    output logic [1:0] cycles
);
    always_comb begin
        cycles = 2'd1;
        unique case (dec.flow)
            FL_BRANCH: cycles = dec.taken ? 2'd2 : 2'd1;
            FL_JUMP:   cycles = 2'd2;
            FL_CALL:   cycles = 2'd3;
            FL_SKIP:   cycles = !dec.taken ? 2'd1 : (two_word ? 2'd3 : 2'd2);
            default:   cycles = 2'd1;
        endcase
    end
endmodule

// File: rtl/bsk_branch_unit.sv
module bsk_branch_unit
    import bsk_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int BR_OFF_W  = 7,
    parameter int JMP_OFF_W = 12,
    parameter int IO_ADDR_W = 6,
    parameter int IO_LIMIT  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [3:0]           req_op,
    input  logic [PC_W-1:0]      pc_in,
    input  logic [7:0]           sreg_in,
    input  logic [2:0]           flag_sel,
    input  logic [JMP_OFF_W-1:0] offset_in,
    input  logic                 reg_bit,
    input  logic                 io_bit,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 eq_in,
    input  logic                 next_two_word,
    output logic                 out_valid,
    output logic                 out_taken,
    output logic [PC_W-1:0]      out_next_pc,
    output logic [1:0]           out_cycles
);
    decision_t       dec;
    logic [PC_W-1:0] nxt_pc;
    logic [1:0]      nxt_cyc;

    bsk_cond_eval #(
        .IO_ADDR_W (IO_ADDR_W),
        .IO_LIMIT  (IO_LIMIT)
    ) i_cond (
        .op       (req_op),
        .sreg     (sreg_in),
        .flag_sel (flag_sel),
        .reg_bit  (reg_bit),
        .io_bit   (io_bit),
        .io_addr  (io_addr),
        .eq       (eq_in),
        .dec      (dec)
    );

    bsk_target_gen #(
        .PC_W      (PC_W),
        .BR_OFF_W  (BR_OFF_W),
        .JMP_OFF_W (JMP_OFF_W)
    ) i_target (
        .pc       (pc_in),
        .offset   (offset_in),
        .dec      (dec),
        .two_word (next_two_word),
        .next_pc  (nxt_pc)
    );

    bsk_cycle_cnt i_cycles (
        .dec      (dec),
        .two_word (next_two_word),
        .cycles   (nxt_cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_cycles  <= 2'd0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_taken   <= dec.taken;
                out_next_pc <= nxt_pc;
                out_cycles  <= nxt_cyc;
            end
        end
    end
endmodule

// File: rtl/bsk_branch_chk.sv
module bsk_branch_chk
    import bsk_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int IO_ADDR_W = 6,
    parameter int IO_LIMIT  = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [3:0]           req_op,
    input logic [PC_W-1:0]      pc_in,
    input logic [7:0]           sreg_in,
    input logic [IO_ADDR_W-1:0] io_addr,
    input logic                 next_two_word,
    input logic                 out_valid,
    input logic                 out_taken,
    input logic [PC_W-1:0]      out_next_pc,
    input logic [1:0]           out_cycles
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);  // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);  // R2
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_taken) |-> out_next_pc == PC_W'($past(pc_in) + 1'b1));  // R10
    AST_SEQ_CYC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_taken) |-> out_cycles == 2'd1);  // R10
    AST_BRANCH_CYC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_taken && $past(req_op) >= OP_BRSET && $past(req_op) <= OP_BRLO)
        |-> out_cycles == 2'd2);  // R6
    AST_SIGNED_GE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_op) == OP_BRGE)
        |-> out_taken == ($past(sreg_in[SF_N]) == $past(sreg_in[SF_V])));  // R4
    AST_JUMP_CYC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_op) == OP_RJMP) |-> (out_taken && out_cycles == 2'd2));  // R7
    AST_CALL_CYC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_op) == OP_RCALL) |-> (out_taken && out_cycles == 2'd3));  // R7
    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_taken && $past(req_op) >= OP_SKEQ && $past(req_op) <= OP_SKIOS)
        |-> out_next_pc == PC_W'($past(pc_in) + ($past(next_two_word) ? 2'd3 : 2'd2)));  // R8
    AST_IO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(req_op) == OP_SKIOC || $past(req_op) == OP_SKIOS)
         && int'($past(io_addr)) >= IO_LIMIT) |-> !out_taken);  // R9
endmodule

bind bsk_branch_unit bsk_branch_chk #(
    .PC_W      (PC_W),
    .IO_ADDR_W (IO_ADDR_W),
    .IO_LIMIT  (IO_LIMIT)
) i_bsk_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .pc_in         (pc_in),
    .sreg_in       (sreg_in),
    .io_addr       (io_addr),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .out_taken     (out_taken),
    .out_next_pc   (out_next_pc),
    .out_cycles    (out_cycles)
);

// File: tb/test_bsk_branch_unit.sv
`timescale 1ns/1ps
module test_bsk_branch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  req_op;
    logic [9:0]  pc_in;
    logic [7:0]  sreg_in;
    logic [2:0]  flag_sel;
    logic [11:0] offset_in;
    logic        reg_bit;
    logic        io_bit;
    logic [5:0]  io_addr;
    logic        eq_in;
    logic        next_two_word;
    logic        out_valid;
    logic        out_taken;
    logic [9:0]  out_next_pc;
    logic [1:0]  out_cycles;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    bsk_branch_unit i_bsk_branch_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .pc_in(pc_in), .sreg_in(sreg_in), .flag_sel(flag_sel),
        .offset_in(offset_in), .reg_bit(reg_bit), .io_bit(io_bit),
        .io_addr(io_addr), .eq_in(eq_in), .next_two_word(next_two_word),
        .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_cycles(out_cycles)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [9:0]  pc;
        logic [7:0]  sr;
        logic [2:0]  fs;
        logic [11:0] off;
        logic        rb;
        logic        iob;
        logic [5:0]  ioa;
        logic        eq;
        logic        tw;
        logic        et;
        logic [9:0]  epc;
        logic [1:0]  ecy;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        // req  op    pc       sreg    fs    off       rb  iob ioa    eq  tw  taken epc      cyc
        '{4'd3,  4'd1, 10'd100, 8'h02, 3'd1, 12'h005, 0, 0, 6'h00, 0, 0, 1, 10'd106,  2'd2}, // R3 set
        '{4'd3,  4'd1, 10'd100, 8'h00, 3'd1, 12'h005, 0, 0, 6'h00, 0, 0, 0, 10'd101,  2'd1}, // R3 R6
        '{4'd3,  4'd2, 10'd200, 8'h00, 3'd6, 12'hF7E, 0, 0, 6'h00, 0, 0, 1, 10'd199,  2'd2}, // R3 high bits ignored
        '{4'd3,  4'd2, 10'd200, 8'h40, 3'd6, 12'hF7E, 0, 0, 6'h00, 0, 0, 0, 10'd201,  2'd1}, // R3
        '{4'd3,  4'd1, 10'd0,   8'h80, 3'd7, 12'h03F, 0, 0, 6'h00, 0, 0, 1, 10'd64,   2'd2}, // R3 top bit
        '{4'd4,  4'd3, 10'd50,  8'h0C, 3'd0, 12'h00A, 0, 0, 6'h00, 0, 0, 1, 10'd61,   2'd2}, // R4 N=V=1
        '{4'd4,  4'd3, 10'd50,  8'h04, 3'd0, 12'h00A, 0, 0, 6'h00, 0, 0, 0, 10'd51,   2'd1}, // R4
        '{4'd4,  4'd4, 10'd50,  8'h08, 3'd0, 12'h040, 0, 0, 6'h00, 0, 0, 1, 10'd1011, 2'd2}, // R4 R11
        '{4'd4,  4'd4, 10'd50,  8'h00, 3'd0, 12'h040, 0, 0, 6'h00, 0, 0, 0, 10'd51,   2'd1}, // R4
        '{4'd5,  4'd5, 10'd300, 8'hFE, 3'd0, 12'h003, 0, 0, 6'h00, 0, 0, 1, 10'd304,  2'd2}, // R5
        '{4'd5,  4'd6, 10'd300, 8'hFE, 3'd0, 12'h003, 0, 0, 6'h00, 0, 0, 0, 10'd301,  2'd1}, // R5
        '{4'd5,  4'd6, 10'd300, 8'h01, 3'd0, 12'h003, 0, 0, 6'h00, 0, 0, 1, 10'd304,  2'd2}, // R5
        '{4'd7,  4'd7, 10'd1000,8'h00, 3'd0, 12'h030, 0, 0, 6'h00, 0, 0, 1, 10'd25,   2'd2}, // R7 R11
        '{4'd7,  4'd7, 10'd10,  8'h00, 3'd0, 12'hFF0, 0, 0, 6'h00, 0, 0, 1, 10'd1019, 2'd2}, // R7
        '{4'd7,  4'd8, 10'd512, 8'h00, 3'd0, 12'h100, 0, 0, 6'h00, 0, 0, 1, 10'd769,  2'd3}, // R7 call
        '{4'd8,  4'd9, 10'd40,  8'h00, 3'd0, 12'h000, 0, 0, 6'h00, 1, 0, 1, 10'd42,   2'd2}, // R8
        '{4'd8,  4'd9, 10'd40,  8'h00, 3'd0, 12'h000, 0, 0, 6'h00, 1, 1, 1, 10'd43,   2'd3}, // R8 two word
        '{4'd10, 4'd9, 10'd40,  8'h00, 3'd0, 12'h000, 0, 0, 6'h00, 0, 1, 0, 10'd41,   2'd1}, // R10
        '{4'd11, 4'd10,10'd1023,8'h00, 3'd0, 12'h000, 0, 0, 6'h00, 0, 0, 1, 10'd1,    2'd2}, // R11 R8
        '{4'd8,  4'd11,10'd7,   8'h00, 3'd0, 12'h000, 0, 0, 6'h00, 0, 0, 0, 10'd8,    2'd1}, // R8
        '{4'd8,  4'd11,10'd7,   8'h00, 3'd0, 12'h000, 1, 0, 6'h00, 0, 1, 1, 10'd10,   2'd3}, // R8
        '{4'd9,  4'd12,10'd60,  8'h00, 3'd0, 12'h000, 0, 0, 6'h1F, 0, 0, 1, 10'd62,   2'd2}, // R9 edge
        '{4'd9,  4'd12,10'd60,  8'h00, 3'd0, 12'h000, 0, 0, 6'h20, 0, 0, 0, 10'd61,   2'd1}, // R9 out
        '{4'd9,  4'd13,10'd60,  8'h00, 3'd0, 12'h000, 0, 1, 6'h00, 0, 1, 1, 10'd63,   2'd3}, // R9
        '{4'd9,  4'd13,10'd60,  8'h00, 3'd0, 12'h000, 0, 1, 6'h3F, 0, 1, 0, 10'd61,   2'd1}, // R9 out
        '{4'd10, 4'd0, 10'd5,   8'hFF, 3'd0, 12'h000, 1, 1, 6'h00, 1, 1, 0, 10'd6,    2'd1}, // R10 none
        '{4'd10, 4'd15,10'd5,   8'hFF, 3'd0, 12'h000, 1, 1, 6'h00, 1, 1, 0, 10'd6,    2'd1}  // R10 unused
    };

    task automatic chk(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        req_valid     = vld;
        req_op        = v.op;
        pc_in         = v.pc;
        sreg_in       = v.sr;
        flag_sel      = v.fs;
        offset_in     = v.off;
        reg_bit       = v.rb;
        io_bit        = v.iob;
        io_addr       = v.ioa;
        eq_in         = v.eq;
        next_two_word = v.tw;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive('0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(1, "valid after reset", int'(out_valid), 0);
        chk(1, "taken after reset", int'(out_taken), 0);
        chk(1, "pc after reset", int'(out_next_pc), 0);
        chk(1, "cycles after reset", int'(out_cycles), 0);

        // Table walk, one request per cycle
        for (int i = 0; i < NV; i++) begin
            drive(VT[i], 1'b1);
            @(negedge clk);
            chk(2, "valid", int'(out_valid), 1);  // R2
            chk(int'(VT[i].req), "taken", int'(out_taken), int'(VT[i].et));
            chk(int'(VT[i].req), "next_pc", int'(out_next_pc), int'(VT[i].epc));
            chk(int'(VT[i].req), "cycles", int'(out_cycles), int'(VT[i].ecy));
        end

        // R2: idle cycle drops valid
        drive(VT[0], 1'b0);
        @(negedge clk);
        chk(2, "valid idle", int'(out_valid), 0);

        // R1: reset wins over a simultaneous request
        drive(VT[12], 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk(1, "valid under reset", int'(out_valid), 0);
        chk(1, "pc under reset", int'(out_next_pc), 0);
        chk(1, "taken under reset", int'(out_taken), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(7, "jump after reset", int'(out_next_pc), 25);  // R7

        drive('0, 1'b0);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule